// File: doc/BRIEF.md
# Selectable Pulse Shortener

The block trims the width of pulses that arrive on several independent detector lines. Each line is first brought into the clock domain by a two-flop synchronizer. The synchronized level then feeds a clocked shift register that offers three delay taps. A single select value, shared by every channel, picks one of those taps or a straight pass. When a tap is in use, the output is the synchronized pulse gated by the inverse of its own delayed copy. Any output pulse therefore ends no later than the tap delay after its rising edge.

The select value is registered once and acts on all channels on the same clock edge. Changing it does not disturb the delay lines, so history collected under one setting still applies under the next. A synchronous, active-high reset clears every synchronizer and delay stage.

Top module: `pulse_trim`

## Requirements
- R1: After reset, every output is 0 while the inputs stay low.
- R2: A level change on an input reaches the synchronized path after exactly two rising clock edges; in pass mode the output rises on the second edge after the input rises.
- R3: With select code 2'b00 (short tap, 8 stages), an input pulse longer than 8 cycles gives an output pulse of exactly 8 cycles.
- R4: With select code 2'b01 (middle tap, 16 stages), an input pulse longer than 16 cycles gives an output pulse of exactly 16 cycles.
- R5: With select code 2'b10 (long tap, 24 stages), an input pulse longer than 24 cycles gives an output pulse of exactly 24 cycles.
- R6: With select code 2'b11 (pass), the output equals the synchronized input, so its pulse has the full input length.
- R7: With a tap of N stages, an input pulse of N cycles or fewer comes out with its length unchanged.
- R8: In tap modes, each output is high in a cycle only when its synchronized input is high and the selected tap value is low.
- R9: Each channel is processed independently; a pulse on one channel never appears on another, and one select value governs all of them.
- R10: A new select value takes effect on the next rising clock edge, and the delay lines keep their contents across the change.
- R11: Reset is synchronous and active high; asserting it during activity forces every output to 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge system clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | NUM_CH (4) | Raw detector pulse lines, one bit per channel |
| trim_sel | input | 2 | Shared mode select: 00 short tap, 01 middle tap, 10 long tap, 11 pass |
| pulse_out | output | NUM_CH (4) | Shortened pulses, one bit per channel |

## Verification
Checked on every cycle: the two-edge synchronizer latency, the upper bound of consecutive high output cycles under a fixed select, the pass mode following the raw input two edges later, and outputs being clear just after reset. Exact output lengths for the three taps, short pulses that stay untouched, channel isolation, and the delay line keeping its history over a select change only show up in the bench scenarios. These are checked against a queue-based reference model on every clock and by explicit pulse-length measurements.

// File: rtl/pulse_trim_pkg.sv
package pulse_trim_pkg;

  typedef enum logic [1:0] {
    TRIM_SHORT  = 2'b00,
    TRIM_MID    = 2'b01,
    TRIM_LONG   = 2'b10,
    TRIM_BYPASS = 2'b11
  } trim_mode_e;

  // Delay in cycles for a given mode; bypass has no limit and returns 0.
  function automatic int unsigned tap_cycles(input trim_mode_e mode,
                                             input int unsigned len_s,
                                             input int unsigned len_m,
                                             input int unsigned len_l);
    case (mode)
      TRIM_SHORT: return len_s;
      TRIM_MID:   return len_m;
      TRIM_LONG:  return len_l;
      default:    return 0;
    endcase
  endfunction

  // Gate a pulse with the inverse of its delayed copy, unless passing.
  function automatic logic gate_pulse(input logic src,
                                      input logic delayed,
                                      input logic pass);
    return pass ? src : (src & ~delayed);
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pt_sync2.sv
module pt_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta_q;
  logic stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

  // R2: output is the input seen two edges earlier
  p_sync_lag_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (q == $past(d, 2)));

endmodule

// File: rtl/pt_delay_line.sv
module pt_delay_line #(
  parameter int unsigned LEN_S = 8,
  parameter int unsigned LEN_M = 16,
  parameter int unsigned LEN_L = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       din,
  output logic [2:0] taps
);
  import pulse_trim_pkg::*;

  localparam int unsigned DEPTH = max3(LEN_S, LEN_M, LEN_L);

  logic [DEPTH-1:0] stage_q;

  // stage 0 takes the input, each later stage takes its neighbour
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < DEPTH; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign taps[0] = stage_q[LEN_S-1];
  assign taps[1] = stage_q[LEN_M-1];
  assign taps[2] = stage_q[LEN_L-1];

endmodule

// File: rtl/pt_trim_gate.sv
module pt_trim_gate #(
  parameter int unsigned LEN_S = 8,
  parameter int unsigned LEN_M = 16,
  parameter int unsigned LEN_L = 24
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        src,
  input  logic [2:0]                  taps,
  input  pulse_trim_pkg::trim_mode_e  mode,
  output logic                        dout
);
  import pulse_trim_pkg::*;

  localparam int unsigned MAXLEN = max3(LEN_S, LEN_M, LEN_L);
  localparam int unsigned RUN_W  = $clog2(MAXLEN + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic picked;
  logic pass;

  always_comb begin
    case (mode)
      TRIM_SHORT: picked = taps[0];
      TRIM_MID:   picked = taps[1];
      TRIM_LONG:  picked = taps[2];
      default:    picked = 1'b0;
    endcase
  end

  assign pass = (mode == TRIM_BYPASS);
  assign dout = gate_pulse(src, picked, pass);

  // Run-length monitor: consecutive high output cycles under one mode.
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_next;
  trim_mode_e       mode_prev_q;
  logic             mode_changed;

  assign mode_changed = (mode != mode_prev_q);

  always_comb begin
    if (!dout)
      run_next = '0;
    else if (mode_changed)
      run_next = RUN_W'(1);
    else if (run_q == RUN_MAX)
      run_next = run_q;
    else
      run_next = run_q + RUN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q       <= '0;
      mode_prev_q <= TRIM_SHORT;
    end else begin
      run_q       <= run_next;
      mode_prev_q <= mode;
    end
  end

  // R3 R4 R5: under a fixed tap, no output run exceeds the tap length
  p_run_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (dout && !pass) |-> (int'(run_next) <= int'(tap_cycles(mode, LEN_S, LEN_M, LEN_L))));

endmodule

// File: rtl/pulse_trim.sv
module pulse_trim #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned LEN_S  = 8,
  parameter int unsigned LEN_M  = 16,
  parameter int unsigned LEN_L  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pulse_in,
  input  logic [1:0]        trim_sel,
  output logic [NUM_CH-1:0] pulse_out
);
  import pulse_trim_pkg::*;

  trim_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= TRIM_SHORT;
    else     mode_q <= trim_mode_e'(trim_sel);
  end

  logic [NUM_CH-1:0] synced;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [2:0] ch_taps;

    pt_sync2 u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pulse_in[c]),
      .q   (synced[c])
    );

    pt_delay_line #(.LEN_S(LEN_S), .LEN_M(LEN_M), .LEN_L(LEN_L)) u_dly (
      .clk  (clk),
      .rst  (rst),
      .din  (synced[c]),
      .taps (ch_taps)
    );

    pt_trim_gate #(.LEN_S(LEN_S), .LEN_M(LEN_M), .LEN_L(LEN_L)) u_gate (
      .clk  (clk),
      .rst  (rst),
      .src  (synced[c]),
      .taps (ch_taps),
      .mode (mode_q),
      .dout (pulse_out[c])
    );

    // R6: in pass mode the output follows the raw input two edges later
    p_pass_follow_r6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2) && mode_q == TRIM_BYPASS)
        |-> (pulse_out[c] == $past(pulse_in[c], 2)));
  end

  // R11: the cycle after reset drops, every output is clear
  p_reset_clear_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pulse_out == '0));

endmodule

// File: tb/tb_pulse_trim.sv
module tb_pulse_trim;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] pulse_in = '0;
  logic [1:0]     trim_sel = 2'b11;
  logic [NCH-1:0] pulse_out;

  pulse_trim dut (
    .clk(clk), .rst(rst), .pulse_in(pulse_in),
    .trim_sel(trim_sel), .pulse_out(pulse_out)
  );

  always #4 clk = ~clk;

  int    checks   = 0;
  int    failures = 0;
  int    cycles   = 0;
  string cur_req  = "R1";

  // Reference model: queue of past synchronized values, newest at front.
  logic [NCH-1:0] m_first, m_sync;
  logic [NCH-1:0] m_hist[$];
  logic [1:0]     m_sel;

  function automatic int lag_of(input logic [1:0] s);
    return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 24;
  endfunction

  function automatic logic [NCH-1:0] model_out();
    if (m_sel == 2'b11) return m_sync;
    return m_sync & ~m_hist[lag_of(m_sel) - 1];
  endfunction

  initial begin
    m_first = '0; m_sync = '0; m_sel = 2'b00;
    for (int i = 0; i < 32; i++) m_hist.push_back('0);
  end

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_first = '0; m_sync = '0; m_sel = 2'b00;
      for (int i = 0; i < 32; i++) m_hist[i] = '0;
    end else begin
      m_hist.push_front(m_sync);
      void'(m_hist.pop_back());
      m_sync  = m_first;
      m_first = pulse_in;
      m_sel   = trim_sel;
    end
  end

  // Per-cycle comparison and output run measurement
  int run_len[NCH];
  int last_len[NCH];
  initial for (int c = 0; c < NCH; c++) begin run_len[c] = 0; last_len[c] = 0; end

  always @(negedge clk) begin
    if (!rst) begin
      logic [NCH-1:0] exp_v;
      exp_v = model_out();
      checks++;
      if (pulse_out !== exp_v) begin
        failures++;
        $display("FAIL %s cycle %0d pulse_out actual %b expected %b",
                 cur_req, cycles, pulse_out, exp_v);
      end
    end
    for (int c = 0; c < NCH; c++) begin
      if (pulse_out[c] === 1'b1) run_len[c]++;
      else if (run_len[c] > 0) begin last_len[c] = run_len[c]; run_len[c] = 0; end
    end
  end

  task automatic check_val(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_lens();
    for (int c = 0; c < NCH; c++) last_len[c] = 0;
  endtask

  // Drive a pulse of len cycles on the channels in mask, then a gap.
  task automatic fire(input logic [NCH-1:0] mask, input int len, input int gap);
    @(negedge clk);
    pulse_in = mask;
    idle(len);
    pulse_in = '0;
    idle(gap);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    finish_run();
  end

  initial begin
    // R1 / R11: reset state
    idle(4);
    rst = 1'b0;
    idle(1);
    check_val("R1 outputs clear after reset", int'(pulse_out), 0);
    idle(5);
    check_val("R1 outputs stay clear", int'(pulse_out), 0);

    // R2: two-edge latency in pass mode
    cur_req = "R2";
    trim_sel = 2'b11;
    idle(3);
    @(negedge clk);
    pulse_in = 4'b0001;
    @(negedge clk);
    check_val("R2 output low after one edge", int'(pulse_out[0]), 0);
    @(negedge clk);
    check_val("R2 output high after two edges", int'(pulse_out[0]), 1);
    pulse_in = '0;
    idle(10);

    // R3 short tap
    cur_req = "R3"; trim_sel = 2'b00; clear_lens(); idle(2);
    fire(4'b0001, 20, 30);
    check_val("R3 short tap length", last_len[0], 8);

    // R4 middle tap
    cur_req = "R4"; trim_sel = 2'b01; clear_lens(); idle(2);
    fire(4'b0010, 40, 40);
    check_val("R4 middle tap length", last_len[1], 16);

    // R5 long tap
    cur_req = "R5"; trim_sel = 2'b10; clear_lens(); idle(2);
    fire(4'b0100, 40, 40);
    check_val("R5 long tap length", last_len[2], 24);

    // R6 pass
    cur_req = "R6"; trim_sel = 2'b11; clear_lens(); idle(2);
    fire(4'b1000, 40, 10);
    check_val("R6 pass keeps full length", last_len[3], 40);

    // R7 short pulses keep their length
    cur_req = "R7"; trim_sel = 2'b01; clear_lens(); idle(2);
    fire(4'b0001, 10, 30);
    check_val("R7 pulse under middle tap", last_len[0], 10);
    trim_sel = 2'b00; clear_lens(); idle(2);
    fire(4'b0001, 8, 30);
    check_val("R7 pulse equal to short tap", last_len[0], 8);

    // R9 channel independence, one select
    cur_req = "R9"; trim_sel = 2'b00; clear_lens(); idle(2);
    @(negedge clk);
    pulse_in = 4'b0110;
    idle(5);
    pulse_in = 4'b0010;
    idle(25);
    pulse_in = '0;
    idle(30);
    check_val("R9 long channel trimmed", last_len[1], 8);
    check_val("R9 short channel intact", last_len[2], 5);
    check_val("R9 idle channel 0 quiet", last_len[0], 0);
    check_val("R9 idle channel 3 quiet", last_len[3], 0);

    // R10 select switch keeps delay history
    cur_req = "R10"; trim_sel = 2'b00; idle(2);
    @(negedge clk);
    pulse_in = 4'b1111;
    idle(30);
    trim_sel = 2'b10;
    @(negedge clk);
    check_val("R10 switch to long tap, history kept", int'(pulse_out), 0);
    idle(3);
    trim_sel = 2'b11;
    @(negedge clk);
    check_val("R10 pass applies next edge", int'(pulse_out), 15);
    pulse_in = '0;
    idle(35);

    // R8 pseudo-random patterns under all modes, compared every cycle
    cur_req = "R8";
    for (int k = 0; k < 1200; k++) begin
      @(negedge clk);
      pulse_in = 4'($urandom());
      if ((k % 150) == 0) trim_sel = 2'($urandom());
    end
    pulse_in = '0;
    idle(30);

    // R11 reset during activity
    cur_req = "R11"; trim_sel = 2'b11; idle(2);
    @(negedge clk);
    pulse_in = 4'b1111;
    idle(6);
    rst = 1'b1;
    @(negedge clk);
    check_val("R11 outputs cleared by reset", int'(pulse_out), 0);
    rst = 1'b0;
    pulse_in = '0;
    idle(30);

    finish_run();
  end

endmodule